// File: doc/BRIEF.md
# Up-Counting Timer with Period and Compare Channels

This block is an 8-bit timer that counts up by one on every cycle its enable is high. A period register sets where the count turns around. When the counter equals the period value on an enabled cycle, the next value is zero. Two compare channels watch the counter all the time. A channel that sees the counter arrive at its compare value by counting raises its own sticky flag. The flag appears after a one-cycle synchronizing stage. A combined interrupt output is high while any flag is set together with its enable bit.

A host reaches the block through a small register bus with a write strobe, a read strobe, a 3-bit address and 8-bit data. It can load the counter, the period and both compare values, and it can read them back. It clears flags by writing ones to them, and it sets the interrupt enables. When a bus write makes the counter equal to a compare value, that write is never counted as a match. This applies to a write of the counter and to a write of the compare value. The period register refuses values below 3 and stores 3 in their place.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter reads 0, both compare values read 0x00, the period reads 0xFF, the flag and interrupt-enable registers read 0, and `irq` is low.
- R2: On an edge where `cnt_en` is high, no counter write is present and the counter differs from the period, the counter goes up by one. On an edge where `cnt_en` is low, it keeps its value.
- R3: On an edge where `cnt_en` is high, no counter write is present and the counter equals the period, the counter becomes 0.
- R4: A value below 3 written to the period register (address 3) is stored as 3. Values of 3 or more are stored unchanged.
- R5: When the counter takes a value by counting and that value equals a channel's compare value, the channel's flag is set two cycles after the first cycle in which the counter shows that value.
- R6: A bus write to the counter (address 0) never produces a match in the cycle that follows it, including when the written value equals a compare value.
- R7: A bus write to a compare register (address 1 for channel A, address 2 for channel B) suppresses that channel's match in the cycle that follows it.
- R8: While the period stays fixed and the counter starts at or below it, a channel whose compare value is above the period never sets its flag.
- R9: Flags live at address 4 (bit 0 channel A, bit 1 channel B). Writing 1 to a bit clears that flag, and writing 0 to a bit leaves it alone. A flag that is cleared in the same cycle it is set stays set.
- R10: `irq` is high exactly when some flag is set and its enable bit is also set. The enables are at address 5, bit 0 for channel A and bit 1 for channel B.
- R11: A read strobe puts the addressed register on `bus_rdata` one cycle later. The data holds between reads. Addresses 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter advances on each edge while high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| irq | output | 1 | Combined interrupt request |

## Verification
Each result has a fixed due cycle:
- A counter value lands one edge after the enabled cycle.
- Read data lands one edge after the read strobe.
- A flag, and the `irq` it drives, lands two edges after the first cycle in which the counter shows the compare value.
- `irq` follows a change of an enable bit or a flag clear on the same edge as the register write.

The bench drives each cycle's inputs at the falling edge and steps its own model once per rising edge. At the next falling edge it compares `irq` and `bus_rdata` with the model, so every check lands in the cycle where the result is due. The directed latency checks sample `irq` in each of the two cycles after the counter reaches a compare value. This shows that the flag is neither early nor late.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_COUNT  = 3'd0,
    SEL_CMP_A  = 3'd1,
    SEL_CMP_B  = 3'd2,
    SEL_PERIOD = 3'd3,
    SEL_FLAGS  = 3'd4,
    SEL_IRQEN  = 3'd5
  } reg_sel_e;

  // compare channel ch sits right after the counter address
  function automatic logic [ADDR_W-1:0] cmp_addr(input int unsigned ch);
    return ADDR_W'(ch + 32'd1);
  endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         counted,
  output logic         wrap
);

  // successor of the count, turning around at the period
  function automatic logic [W-1:0] next_count(input logic [W-1:0] c,
                                               input logic [W-1:0] p);
    return (c == p) ? '0 : c + 1'b1;
  endfunction

  assign wrap = en && !load && (cnt == period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      counted <= 1'b0;
    end else begin
      // the value held next cycle came from counting only
      counted <= en && !load;
      if (load) begin
        cnt <= load_val;
      end else if (en) begin
        cnt <= next_count(cnt, period);
      end
    end
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         counted,
  input  logic         cmp_load,
  input  logic [W-1:0] cmp_wdata,
  input  logic         flag_clr,
  output logic [W-1:0] cmp,
  output logic         match_evt,
  output logic         hit,
  output logic         flag
);

  logic cmp_wr_q;

  // equality counts only when the counter got there by counting and the
  // compare value was not just rewritten
  assign match_evt = counted && !cmp_wr_q && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp      <= '0;
      cmp_wr_q <= 1'b0;
      hit      <= 1'b0;
      flag     <= 1'b0;
    end else begin
      cmp_wr_q <= cmp_load;
      if (cmp_load) begin
        cmp <= cmp_wdata;
      end
      hit  <= match_evt;
      flag <= hit || (flag && !flag_clr);
    end
  end

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import cmp_timer_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned MIN_PERIOD  = 3,
  parameter int unsigned PERIOD_INIT = 255
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic                          rd,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [W-1:0]                  wdata,
  input  logic [W-1:0]                  cnt,
  input  logic [NUM_CH-1:0][W-1:0]      cmp_vals,
  input  logic [NUM_CH-1:0]             flags,
  output logic                          cnt_load,
  output logic [NUM_CH-1:0]             cmp_load,
  output logic [NUM_CH-1:0]             flag_clr,
  output logic [W-1:0]                  period,
  output logic [NUM_CH-1:0]             irq_en,
  output logic [W-1:0]                  rdata
);

  localparam logic [W-1:0] PER_FLOOR = W'(MIN_PERIOD);
  localparam logic [W-1:0] PER_RST   = W'(PERIOD_INIT);

  function automatic logic [W-1:0] clamp_period(input logic [W-1:0] v);
    return (v < PER_FLOOR) ? PER_FLOOR : v;
  endfunction

  function automatic logic [W-1:0] widen(input logic [NUM_CH-1:0] v);
    return {{(W-NUM_CH){1'b0}}, v};
  endfunction

  logic          per_load;
  logic          ien_load;
  logic [W-1:0]  rd_mux;

  assign cnt_load = wr && (addr == SEL_COUNT);
  assign per_load = wr && (addr == SEL_PERIOD);
  assign ien_load = wr && (addr == SEL_IRQEN);
  assign flag_clr = (wr && (addr == SEL_FLAGS)) ? wdata[NUM_CH-1:0] : '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp_dec
    assign cmp_load[g] = wr && (addr == cmp_addr(g));
  end

  always_comb begin
    rd_mux = '0;
    if (addr == SEL_COUNT)  rd_mux = cnt;
    if (addr == SEL_PERIOD) rd_mux = period;
    if (addr == SEL_FLAGS)  rd_mux = widen(flags);
    if (addr == SEL_IRQEN)  rd_mux = widen(irq_en);
    for (int unsigned i = 0; i < NUM_CH; i++) begin
      if (addr == cmp_addr(i)) rd_mux = cmp_vals[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period <= PER_RST;
      irq_en <= '0;
      rdata  <= '0;
    end else begin
      if (per_load) period <= clamp_period(wdata);
      if (ien_load) irq_en <= wdata[NUM_CH-1:0];
      if (rd)       rdata  <= rd_mux;
    end
  end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned MIN_PERIOD  = 3,
  parameter int unsigned PERIOD_INIT = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);

  logic                         cnt_load;
  logic [CNT_W-1:0]             cnt;
  logic                         counted;
  logic                         wrap;
  logic [CNT_W-1:0]             period;
  logic [NUM_CH-1:0]            cmp_load;
  logic [NUM_CH-1:0]            flag_clr;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_vals;
  logic [NUM_CH-1:0]            match_evt;
  logic [NUM_CH-1:0]            hit;
  logic [NUM_CH-1:0]            flags;
  logic [NUM_CH-1:0]            irq_en;

  tmr_regif #(
    .W          (CNT_W),
    .MIN_PERIOD (MIN_PERIOD),
    .PERIOD_INIT(PERIOD_INIT)
  ) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .cnt      (cnt),
    .cmp_vals (cmp_vals),
    .flags    (flags),
    .cnt_load (cnt_load),
    .cmp_load (cmp_load),
    .flag_clr (flag_clr),
    .period   (period),
    .irq_en   (irq_en),
    .rdata    (bus_rdata)
  );

  tmr_counter #(.W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cnt_en),
    .load     (cnt_load),
    .load_val (bus_wdata),
    .period   (period),
    .cnt      (cnt),
    .counted  (counted),
    .wrap     (wrap)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    tmr_channel #(.W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt       (cnt),
      .counted   (counted),
      .cmp_load  (cmp_load[g]),
      .cmp_wdata (bus_wdata),
      .flag_clr  (flag_clr[g]),
      .cmp       (cmp_vals[g]),
      .match_evt (match_evt[g]),
      .hit       (hit[g]),
      .flag      (flags[g])
    );
  end

  assign irq = |(flags & irq_en);

endmodule

// File: rtl/cmp_timer_checker.sv
module cmp_timer_checker
  import cmp_timer_pkg::*;
#(
  parameter int unsigned W          = 8,
  parameter int unsigned MIN_PERIOD = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic              cnt_load,
  input logic [W-1:0]      cnt,
  input logic              wrap,
  input logic [W-1:0]      period,
  input logic [NUM_CH-1:0] cmp_load,
  input logic [NUM_CH-1:0] match_evt,
  input logic [NUM_CH-1:0] hit,
  input logic [NUM_CH-1:0] flags,
  input logic [NUM_CH-1:0] flag_clr,
  input logic [NUM_CH-1:0] irq_en,
  input logic              irq
);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_load && cnt != period) |=> (cnt == W'($past(cnt) + 1'b1)));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cnt_load) |=> $stable(cnt));

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  assert_period_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    period >= W'(MIN_PERIOD));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(flags & irq_en)));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assert_match_to_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt[g] |=> hit[g]);

    assert_hit_to_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> flags[g]);

    assert_cnt_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load |=> !match_evt[g]);

    assert_cmp_write_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_load[g] |=> !match_evt[g]);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !flag_clr[g]) |=> flags[g]);
  end

endmodule

bind cmp_timer cmp_timer_checker #(
  .W          (CNT_W),
  .MIN_PERIOD (MIN_PERIOD)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_en    (cnt_en),
  .cnt_load  (cnt_load),
  .cnt       (cnt),
  .wrap      (wrap),
  .period    (period),
  .cmp_load  (cmp_load),
  .match_evt (match_evt),
  .hit       (hit),
  .flags     (flags),
  .flag_clr  (flag_clr),
  .irq_en    (irq_en),
  .irq       (irq)
);

// File: tb/test_cmp_timer.sv
module test_cmp_timer;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer i_cmp_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // behavioural model of the register-visible state
  logic [7:0] m_cnt = 8'd0;
  logic [7:0] m_per = 8'hFF;
  logic [7:0] m_rd  = 8'd0;
  logic [7:0] m_cmp [2] = '{8'd0, 8'd0};
  bit         m_flag [2] = '{0, 0};
  bit         m_hit  [2] = '{0, 0};
  bit         m_cwr  [2] = '{0, 0};
  bit         m_counted = 0;
  bit  [1:0]  m_ie = 2'b00;

  function automatic bit model_irq();
    return (m_flag[0] && m_ie[0]) || (m_flag[1] && m_ie[1]);
  endfunction

  task automatic model_step(input bit en, input bit wr, input bit rd,
                            input int a, input logic [7:0] d);
    bit evt [2];
    logic [7:0] rv;
    case (a)
      0: rv = m_cnt;
      1: rv = m_cmp[0];
      2: rv = m_cmp[1];
      3: rv = m_per;
      4: rv = {6'd0, m_flag[1], m_flag[0]};
      5: rv = {6'd0, m_ie};
      default: rv = 8'd0;
    endcase
    for (int i = 0; i < 2; i++)
      evt[i] = m_counted && !m_cwr[i] && (m_cnt == m_cmp[i]);
    for (int i = 0; i < 2; i++) begin
      if (m_hit[i]) m_flag[i] = 1;
      else if (wr && a == 4 && d[i]) m_flag[i] = 0;
      m_hit[i] = evt[i];
      m_cwr[i] = wr && (a == i + 1);
      if (m_cwr[i]) m_cmp[i] = d;
    end
    m_counted = en && !(wr && a == 0);
    if (wr && a == 0) m_cnt = d;
    else if (en) m_cnt = (m_cnt == m_per) ? 8'd0 : m_cnt + 8'd1;
    if (wr && a == 3) m_per = (d < 8'd3) ? 8'd3 : d;
    if (wr && a == 5) m_ie = d[1:0];
    if (rd) m_rd = rv;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at the falling edge, model at the rising edge,
  // compare at the next falling edge
  task automatic tick(input bit en, input bit wr, input bit rd,
                      input int a, input logic [7:0] d);
    cnt_en    = en;
    bus_wr    = wr;
    bus_rd    = rd;
    bus_addr  = 3'(a);
    bus_wdata = d;
    @(posedge clk);
    model_step(en, wr, rd, a, d);
    @(negedge clk);
    chk(irq == model_irq(), "R10 irq vs model", int'(irq), int'(model_irq()));
    chk(bus_rdata == m_rd, "R11 rdata vs model", int'(bus_rdata), int'(m_rd));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 8'd0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(1, 0, 0, 0, 8'd0);
  endtask

  task automatic wr_reg(input int a, input logic [7:0] d);
    tick(0, 1, 0, a, d);
  endtask

  task automatic rd_chk(input int a, input logic [7:0] exp, input string tag);
    tick(0, 0, 1, a, 8'd0);
    chk(bus_rdata == exp, tag, int'(bus_rdata), int'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
    rd_chk(0, 8'd0,  "R1 counter");
    rd_chk(1, 8'd0,  "R1 compare A");
    rd_chk(2, 8'd0,  "R1 compare B");
    rd_chk(3, 8'hFF, "R1 period");
    rd_chk(4, 8'd0,  "R1 flags");
    rd_chk(5, 8'd0,  "R1 irq enables");

    // R4 period floor
    wr_reg(3, 8'd1);   rd_chk(3, 8'd3,   "R4 write 1");
    wr_reg(3, 8'd0);   rd_chk(3, 8'd3,   "R4 write 0");
    wr_reg(3, 8'd2);   rd_chk(3, 8'd3,   "R4 write 2");
    wr_reg(3, 8'd3);   rd_chk(3, 8'd3,   "R4 write 3");
    wr_reg(3, 8'd200); rd_chk(3, 8'd200, "R4 write 200");

    wr_reg(3, 8'd10);
    wr_reg(1, 8'd4);
    wr_reg(2, 8'd7);
    wr_reg(5, 8'd3);

    // R3 wrap at the period
    wr_reg(0, 8'd8);
    run(3);
    rd_chk(0, 8'd0, "R3 wrap to zero");

    // R2 counting and holding
    wr_reg(0, 8'd2);
    run(5);
    rd_chk(0, 8'd7, "R2 count by five");
    idle(4);
    rd_chk(0, 8'd7, "R2 hold while disabled");
    rd_chk(4, 8'd3, "R5 both flags from counting");
    chk(irq == 1'b1, "R10 irq with flags enabled", int'(irq), 1);

    // R10 enable gating
    wr_reg(5, 8'd0);
    chk(irq == 1'b0, "R10 irq masked", int'(irq), 0);
    wr_reg(5, 8'd2);
    chk(irq == 1'b1, "R10 irq via channel B", int'(irq), 1);
    wr_reg(5, 8'd3);

    // R9 write-one-to-clear
    wr_reg(4, 8'd1); rd_chk(4, 8'd2, "R9 clear A only");
    wr_reg(4, 8'd0); rd_chk(4, 8'd2, "R9 zero write no effect");
    wr_reg(4, 8'd2); rd_chk(4, 8'd0, "R9 clear B");
    chk(irq == 1'b0, "R10 irq after clear", int'(irq), 0);

    // R6 counter write onto the compare value
    tick(1, 1, 0, 0, 8'd4);
    run(1);
    idle(3);
    rd_chk(4, 8'd0, "R6 no flag after counter write");
    rd_chk(0, 8'd5, "R6 counter moved on");

    // R7 compare write onto the next count
    wr_reg(0, 8'd5);
    tick(1, 1, 0, 1, 8'd6);
    idle(3);
    rd_chk(4, 8'd0, "R7 no flag after compare write");
    rd_chk(1, 8'd6, "R7 compare stored");

    // R5 flag latency: counter shows 6 in the cycle after the enabled edge
    wr_reg(0, 8'd5);
    run(1);
    chk(irq == 1'b0, "R5 not yet on match cycle", int'(irq), 0);
    idle(1);
    chk(irq == 1'b0, "R5 not yet in sync stage", int'(irq), 0);
    idle(1);
    chk(irq == 1'b1, "R5 flag due two cycles on", int'(irq), 1);

    // R9 set wins over a clear in the same cycle
    wr_reg(4, 8'd3);
    rd_chk(4, 8'd0, "R9 cleared before race");
    wr_reg(0, 8'd5);
    run(1);
    idle(1);
    wr_reg(4, 8'd1);
    rd_chk(4, 8'd1, "R9 set wins over clear");
    wr_reg(4, 8'd1);
    rd_chk(4, 8'd0, "R9 cleared after race");

    // R8 compare above the period
    wr_reg(1, 8'd12);
    wr_reg(2, 8'd11);
    wr_reg(4, 8'd3);
    wr_reg(0, 8'd0);
    run(40);
    idle(2);
    rd_chk(4, 8'd0, "R8 compare beyond period never flags");

    // R4 smallest period still matches
    wr_reg(3, 8'd1);
    wr_reg(1, 8'd3);
    wr_reg(4, 8'd3);
    wr_reg(0, 8'd0);
    run(10);
    idle(2);
    rd_chk(4, 8'd1, "R4 clamped period reaches 3");

    // R11 unused address and data hold
    wr_reg(6, 8'h5A);
    rd_chk(6, 8'd0, "R11 unused address reads 0");
    rd_chk(1, 8'd3, "R11 unused write left compare A");
    idle(1);
    chk(bus_rdata == 8'd3, "R11 rdata holds without read", int'(bus_rdata), 3);

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      bit en_r = ($urandom_range(3, 0) != 0);
      bit wr_r = ($urandom_range(5, 0) == 0);
      bit rd_r = ($urandom_range(1, 0) == 0);
      int a_r  = int'($urandom_range(7, 0));
      logic [7:0] d_r = 8'($urandom_range(14, 0));
      tick(en_r, wr_r, rd_r, a_r, d_r);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule